// File: doc/BRIEF.md
# HALT/STOP Power-Mode Controller

This block watches the instruction stream of an 8-bit processor and puts the chip into one of two sleep states when a sleep opcode arrives. In the light sleep (HALT) only the processor clock is gated. The oscillator, the counter/timers and the interrupt logic keep running, and any interrupt brings the processor back. It then resumes with the next instruction in sequence. In the deep sleep (STOP) the processor clock is gated and the oscillator is shut down. Only a reset-class event ends that state, and it restarts the program at a fixed vector.

A sleep opcode is obeyed only when the instruction executed just before it was a NOP. This ensures that the pipeline holds no half-finished instruction. Any other sleep opcode does nothing. The outputs are clock enables for the clock gating cells and one-cycle strobes for the processor core. The gating cells and the core are outside this block.

Top module: `sleep_mode_ctrl`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `cpuClkEn`, `oscEn` and `periphClkEn` are 1 and `wakeStrobe` and `restartLoad` are 0.
- R2: In the running state, a cycle with `opValid`=1, `opCode`=0x7F and `prevOpCode`=0xFF enters HALT. From the next cycle, `cpuClkEn`=0 while `oscEn` and `periphClkEn` stay 1.
- R3: In the running state, a cycle with `opValid`=1, `opCode`=0x6F and `prevOpCode`=0xFF enters STOP. From the next cycle, `cpuClkEn`, `oscEn` and `periphClkEn` are all 0.
- R4: A sleep opcode has no effect and all enables stay 1 when `prevOpCode` is not 0xFF, or when `opValid` is 0.
- R5: In HALT, a 1 on any bit of `irqExt[3:0]`, or on `irqInt`, sets `cpuClkEn` to 1 on the next cycle. `wakeStrobe` is 1 for that one cycle, and `restartLoad` stays 0.
- R6: In STOP, interrupts and opcodes are ignored. All enables stay 0 and `wakeStrobe` stays 0.
- R7: Any bit of `rstSrc` at 1 (bit 0 watchdog time-out, bit 1 power-on, bit 2 stop-mode recovery, bit 3 external reset) returns the block to the running state with all enables at 1 on the next cycle, from any state. `restartLoad` is 1 for exactly that cycle. `restartAddr` is always 0x000C.
- R8: A reset-class event takes priority over a legal sleep opcode or an interrupt in the same cycle. In that case the block ends up running, with `wakeStrobe`=0 and `restartLoad`=1.
- R9: In HALT with no interrupt and no reset-class event, opcodes are ignored and the block stays in HALT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | `opCode` holds an instruction being executed |
| opCode | input | 8 | Current opcode |
| prevOpCode | input | 8 | Opcode executed just before `opCode` |
| irqExt | input | 4 | External interrupt requests |
| irqInt | input | 1 | Any internal interrupt request |
| rstSrc | input | 4 | Reset-class events: watchdog, power-on, stop recovery, external |
| cpuClkEn | output | 1 | Processor clock enable |
| oscEn | output | 1 | Crystal oscillator enable |
| periphClkEn | output | 1 | Counter/timer and interrupt logic clock enable |
| wakeStrobe | output | 1 | One-cycle pulse when HALT ends through an interrupt |
| restartLoad | output | 1 | One-cycle pulse telling the core to load `restartAddr` |
| restartAddr | output | 16 | Fixed restart vector, 0x000C |

## Verification
Two pairs of functions can fall in the same cycle. The first is a reset-class event arriving together with an interrupt while halted. The second is a reset-class event arriving together with a legal sleep opcode while running. The bench drives both pairs in one cycle and checks that the reset path wins: the enables are all 1, `restartLoad` pulses and `wakeStrobe` stays low. A behavioural reference model is compared with the outputs on every clock, so any extra wake pulse or any leftover gating is caught on the cycle it appears.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_STOP = 2'd2
  } pwrMode_e;

  // Strobes from the control FSM to the enable/pulse datapath.
  typedef struct packed {
    logic gateCpu;   // remove processor clock
    logic haltOsc;   // shut oscillator and peripheral clock
    logic wake;      // interrupt ended the light sleep
    logic restart;   // reset-class event: everything back on, load vector
  } modeStrobe_t;

endpackage

// File: rtl/sleep_dp.sv
module sleep_dp
  import sleep_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int IRQ_N  = 4,
  parameter int RST_N  = 4,
  parameter int ADDR_W = 16,
  parameter logic [OP_W-1:0]   HALT_OP     = 8'h7F,
  parameter logic [OP_W-1:0]   STOP_OP     = 8'h6F,
  parameter logic [OP_W-1:0]   NOP_OP      = 8'hFF,
  parameter logic [ADDR_W-1:0] RESTART_VEC = 16'h000C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [OP_W-1:0]   prevOpCode,
  input  logic [IRQ_N-1:0]  irqExt,
  input  logic              irqInt,
  input  logic [RST_N-1:0]  rstSrc,
  input  modeStrobe_t       strobe,
  output logic              haltReq,
  output logic              stopReq,
  output logic              wakeReq,
  output logic              rstReq,
  output logic              cpuClkEn,
  output logic              oscEn,
  output logic              periphClkEn,
  output logic              wakeStrobe,
  output logic              restartLoad,
  output logic [ADDR_W-1:0] restartAddr
);

  localparam int SRC_N = IRQ_N + 1;

  logic             pipeFlushed;
  logic [SRC_N-1:0] wakeSrc;
  logic [SRC_N-1:0] wakeAcc;
  logic [RST_N-1:0] rstAcc;

  assign pipeFlushed = (prevOpCode == NOP_OP);
  assign haltReq     = opValid && pipeFlushed && (opCode == HALT_OP);
  assign stopReq     = opValid && pipeFlushed && (opCode == STOP_OP);

  assign wakeSrc = {irqInt, irqExt};

  // Ripple OR over wake and reset sources.
  genvar gi;
  generate
    for (gi = 0; gi < SRC_N; gi++) begin : g_wake
      if (gi == 0) begin : g_first
        assign wakeAcc[gi] = wakeSrc[gi];
      end else begin : g_next
        assign wakeAcc[gi] = wakeAcc[gi-1] | wakeSrc[gi];
      end
    end
    for (gi = 0; gi < RST_N; gi++) begin : g_rst
      if (gi == 0) begin : g_first
        assign rstAcc[gi] = rstSrc[gi];
      end else begin : g_next
        assign rstAcc[gi] = rstAcc[gi-1] | rstSrc[gi];
      end
    end
  endgenerate

  assign wakeReq = wakeAcc[SRC_N-1];
  assign rstReq  = rstAcc[RST_N-1];

  logic cpuEnQ, oscEnQ, perEnQ, wakeQ, restartQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuEnQ   <= 1'b1;
      oscEnQ   <= 1'b1;
      perEnQ   <= 1'b1;
      wakeQ    <= 1'b0;
      restartQ <= 1'b0;
    end else if (strobe.restart) begin
      cpuEnQ   <= 1'b1;
      oscEnQ   <= 1'b1;
      perEnQ   <= 1'b1;
      wakeQ    <= 1'b0;
      restartQ <= 1'b1;
    end else begin
      restartQ <= 1'b0;
      wakeQ    <= strobe.wake;
      if (strobe.gateCpu) begin
        cpuEnQ <= 1'b0;
      end else if (strobe.wake) begin
        cpuEnQ <= 1'b1;
      end
      if (strobe.haltOsc) begin
        oscEnQ <= 1'b0;
        perEnQ <= 1'b0;
      end
    end
  end

  assign cpuClkEn    = cpuEnQ;
  assign oscEn       = oscEnQ;
  assign periphClkEn = perEnQ;
  assign wakeStrobe  = wakeQ;
  assign restartLoad = restartQ;
  assign restartAddr = RESTART_VEC;

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        haltReq,
  input  logic        stopReq,
  input  logic        wakeReq,
  input  logic        rstReq,
  output modeStrobe_t strobe
);

  pwrMode_e modeQ, modeNext;

  always_comb begin
    strobe   = '0;
    modeNext = modeQ;
    if (rstReq) begin
      strobe.restart = 1'b1;
      modeNext       = MODE_RUN;
    end else begin
      unique case (modeQ)
        MODE_RUN: begin
          if (stopReq) begin
            strobe.gateCpu = 1'b1;
            strobe.haltOsc = 1'b1;
            modeNext       = MODE_STOP;
          end else if (haltReq) begin
            strobe.gateCpu = 1'b1;
            modeNext       = MODE_HALT;
          end
        end
        MODE_HALT: begin
          if (wakeReq) begin
            strobe.wake = 1'b1;
            modeNext    = MODE_RUN;
          end
        end
        MODE_STOP: begin
          modeNext = MODE_STOP;
        end
        default: begin
          modeNext = MODE_RUN;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_RUN;
    end else begin
      modeQ <= modeNext;
    end
  end

endmodule

// File: rtl/sleep_mode_ctrl.sv
module sleep_mode_ctrl
  import sleep_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int IRQ_N  = 4,
  parameter int RST_N  = 4,
  parameter int ADDR_W = 16,
  parameter logic [OP_W-1:0]   HALT_OP     = 8'h7F,
  parameter logic [OP_W-1:0]   STOP_OP     = 8'h6F,
  parameter logic [OP_W-1:0]   NOP_OP      = 8'hFF,
  parameter logic [ADDR_W-1:0] RESTART_VEC = 16'h000C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [OP_W-1:0]   prevOpCode,
  input  logic [IRQ_N-1:0]  irqExt,
  input  logic              irqInt,
  input  logic [RST_N-1:0]  rstSrc,
  output logic              cpuClkEn,
  output logic              oscEn,
  output logic              periphClkEn,
  output logic              wakeStrobe,
  output logic              restartLoad,
  output logic [ADDR_W-1:0] restartAddr
);

  modeStrobe_t strobe;
  logic haltReq, stopReq, wakeReq, rstReq;

  sleep_fsm u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .haltReq (haltReq),
    .stopReq (stopReq),
    .wakeReq (wakeReq),
    .rstReq  (rstReq),
    .strobe  (strobe)
  );

  sleep_dp #(
    .OP_W(OP_W), .IRQ_N(IRQ_N), .RST_N(RST_N), .ADDR_W(ADDR_W),
    .HALT_OP(HALT_OP), .STOP_OP(STOP_OP), .NOP_OP(NOP_OP),
    .RESTART_VEC(RESTART_VEC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .opCode      (opCode),
    .prevOpCode  (prevOpCode),
    .irqExt      (irqExt),
    .irqInt      (irqInt),
    .rstSrc      (rstSrc),
    .strobe      (strobe),
    .haltReq     (haltReq),
    .stopReq     (stopReq),
    .wakeReq     (wakeReq),
    .rstReq      (rstReq),
    .cpuClkEn    (cpuClkEn),
    .oscEn       (oscEn),
    .periphClkEn (periphClkEn),
    .wakeStrobe  (wakeStrobe),
    .restartLoad (restartLoad),
    .restartAddr (restartAddr)
  );

endmodule

// File: rtl/sleep_mode_ctrl_chk.sv
module sleep_mode_ctrl_chk #(
  parameter int OP_W   = 8,
  parameter int IRQ_N  = 4,
  parameter int RST_N  = 4,
  parameter int ADDR_W = 16,
  parameter logic [OP_W-1:0]   HALT_OP     = 8'h7F,
  parameter logic [OP_W-1:0]   STOP_OP     = 8'h6F,
  parameter logic [OP_W-1:0]   NOP_OP      = 8'hFF,
  parameter logic [ADDR_W-1:0] RESTART_VEC = 16'h000C
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [OP_W-1:0]   opCode,
  input logic [OP_W-1:0]   prevOpCode,
  input logic [IRQ_N-1:0]  irqExt,
  input logic              irqInt,
  input logic [RST_N-1:0]  rstSrc,
  input logic              cpuClkEn,
  input logic              oscEn,
  input logic              periphClkEn,
  input logic              wakeStrobe,
  input logic              restartLoad,
  input logic [ADDR_W-1:0] restartAddr
);

  logic quiet, anyIrq, flushed;
  assign quiet   = (rstSrc == '0);
  assign anyIrq  = (irqExt != '0) || irqInt;
  assign flushed = opValid && (prevOpCode == NOP_OP);

  // R1
  resetState_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cpuClkEn && oscEn && periphClkEn && !wakeStrobe && !restartLoad));

  // R2
  haltEntry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && quiet && flushed && opCode == HALT_OP)
      |=> (!cpuClkEn && oscEn && periphClkEn));

  // R3
  stopEntry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && quiet && flushed && opCode == STOP_OP)
      |=> (!cpuClkEn && !oscEn && !periphClkEn));

  // R4
  noEntry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && quiet && !flushed) |=> (cpuClkEn && oscEn));

  // R5
  haltWake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && oscEn && quiet && anyIrq)
      |=> (cpuClkEn && wakeStrobe && !restartLoad));

  // R6
  stopHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && quiet) |=> (!oscEn && !periphClkEn && !cpuClkEn && !wakeStrobe));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !quiet |=> (cpuClkEn && oscEn && periphClkEn && restartLoad));

  // R7
  vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartAddr == RESTART_VEC);

  // R8
  wakeNoReset_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeStrobe |-> (!restartLoad && $past(quiet)));

  // R9
  haltHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && oscEn && quiet && !anyIrq) |=> (!cpuClkEn && oscEn && !wakeStrobe));

endmodule

bind sleep_mode_ctrl sleep_mode_ctrl_chk #(
  .OP_W(OP_W), .IRQ_N(IRQ_N), .RST_N(RST_N), .ADDR_W(ADDR_W),
  .HALT_OP(HALT_OP), .STOP_OP(STOP_OP), .NOP_OP(NOP_OP),
  .RESTART_VEC(RESTART_VEC)
) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
  .prevOpCode(prevOpCode), .irqExt(irqExt), .irqInt(irqInt),
  .rstSrc(rstSrc), .cpuClkEn(cpuClkEn), .oscEn(oscEn),
  .periphClkEn(periphClkEn), .wakeStrobe(wakeStrobe),
  .restartLoad(restartLoad), .restartAddr(restartAddr)
);

// File: tb/tb_sleep_mode_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_mode_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opCode = 8'h00;
  logic [7:0]  prevOpCode = 8'h00;
  logic [3:0]  irqExt = 4'h0;
  logic        irqInt = 1'b0;
  logic [3:0]  rstSrc = 4'h0;
  logic        cpuClkEn, oscEn, periphClkEn, wakeStrobe, restartLoad;
  logic [15:0] restartAddr;

  always #4 clk = ~clk;

  sleep_mode_ctrl dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .prevOpCode(prevOpCode), .irqExt(irqExt), .irqInt(irqInt),
    .rstSrc(rstSrc), .cpuClkEn(cpuClkEn), .oscEn(oscEn),
    .periphClkEn(periphClkEn), .wakeStrobe(wakeStrobe),
    .restartLoad(restartLoad), .restartAddr(restartAddr)
  );

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  bit    done = 0;
  string tag = "R1";

  // Behavioural reference: 0 running, 1 light sleep, 2 deep sleep.
  int mMode = 0;
  bit mWake = 0;
  bit mRestart = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mWake = 0; mRestart = 0;
    end else begin
      mWake = 0; mRestart = 0;
      if (rstSrc != 0) begin
        mMode = 0; mRestart = 1;
      end else if (mMode == 0) begin
        if (opValid && prevOpCode == 8'hFF && opCode == 8'h6F) mMode = 2;
        else if (opValid && prevOpCode == 8'hFF && opCode == 8'h7F) mMode = 1;
      end else if (mMode == 1) begin
        if (irqExt != 0 || irqInt) begin
          mMode = 0; mWake = 1;
        end
      end
    end
  end

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(tag, "cpuClkEn", 16'(cpuClkEn), 16'(mMode == 0));
      check(tag, "oscEn", 16'(oscEn), 16'(mMode != 2));
      check(tag, "periphClkEn", 16'(periphClkEn), 16'(mMode != 2));
      check(tag, "wakeStrobe", 16'(wakeStrobe), 16'(mWake));
      check(tag, "restartLoad", 16'(restartLoad), 16'(mRestart));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic v, logic [7:0] op, logic [7:0] prev);
    @(negedge clk);
    opValid = v; opCode = op; prevOpCode = prev;
    @(negedge clk);
    opValid = 0; opCode = 8'h00; prevOpCode = op;
  endtask

  task automatic pulseIrq(logic [3:0] e, logic i);
    @(negedge clk);
    irqExt = e; irqInt = i;
    @(negedge clk);
    irqExt = 0; irqInt = 0;
  endtask

  task automatic pulseRst(logic [3:0] s);
    @(negedge clk);
    rstSrc = s;
    @(negedge clk);
    rstSrc = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    idle(3);
    check("R1", "cpuClkEn in reset", 16'(cpuClkEn), 16'd1);
    check("R1", "restartLoad in reset", 16'(restartLoad), 16'd0);
    rstN = 1;
    idle(2);

    tag = "R4";
    issue(1, 8'h7F, 8'h3A);
    issue(1, 8'h6F, 8'h00);
    issue(0, 8'h7F, 8'hFF);
    idle(1);
    check("R4", "cpuClkEn after unflushed sleep", 16'(cpuClkEn), 16'd1);

    tag = "R2";
    issue(1, 8'h7F, 8'hFF);
    check("R2", "cpuClkEn in light sleep", 16'(cpuClkEn), 16'd0);
    check("R2", "oscEn in light sleep", 16'(oscEn), 16'd1);
    tag = "R9";
    idle(3);
    issue(1, 8'h6F, 8'hFF);
    idle(2);
    check("R9", "oscEn after opcode in light sleep", 16'(oscEn), 16'd1);
    tag = "R5";
    pulseIrq(4'b0100, 0);
    idle(1);
    tag = "R2";
    issue(1, 8'h7F, 8'hFF);
    tag = "R5";
    pulseIrq(4'b0000, 1);
    idle(2);

    tag = "R3";
    issue(1, 8'h6F, 8'hFF);
    check("R3", "oscEn in deep sleep", 16'(oscEn), 16'd0);
    tag = "R6";
    pulseIrq(4'b1111, 1);
    issue(1, 8'h7F, 8'hFF);
    idle(2);
    check("R6", "cpuClkEn in deep sleep", 16'(cpuClkEn), 16'd0);
    tag = "R7";
    pulseRst(4'b0001);
    check("R7", "restartAddr", restartAddr, 16'h000C);
    idle(1);
    for (int k = 1; k < 4; k++) begin
      tag = "R3";
      issue(1, 8'h6F, 8'hFF);
      tag = "R7";
      pulseRst(4'(1 << k));
      idle(1);
    end
    pulseRst(4'b1000);
    idle(1);

    tag = "R8";
    issue(1, 8'h7F, 8'hFF);
    @(negedge clk);
    irqExt = 4'b0001; rstSrc = 4'b0010;
    @(negedge clk);
    irqExt = 0; rstSrc = 0;
    check("R8", "wakeStrobe with reset", 16'(wakeStrobe), 16'd0);
    check("R8", "restartLoad with reset", 16'(restartLoad), 16'd1);
    @(negedge clk);
    opValid = 1; opCode = 8'h6F; prevOpCode = 8'hFF; rstSrc = 4'b0100;
    @(negedge clk);
    opValid = 0; opCode = 0; prevOpCode = 0; rstSrc = 0;
    check("R8", "oscEn after stop with reset", 16'(oscEn), 16'd1);
    idle(2);

    tag = "R1";
    issue(1, 8'h7F, 8'hFF);
    @(negedge clk);
    rstN = 0;
    idle(2);
    rstN = 1;
    idle(1);
    check("R1", "cpuClkEn after reset in sleep", 16'(cpuClkEn), 16'd1);
    idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule